// File: doc/BRIEF.md
# Vehicle-Actuated Two-Road Signal Controller

This block runs the lamps at a junction where a main road crosses a side road. The controller steps through four phases in a fixed order: main green, main yellow, side green, side yellow, and then back to main green. The main road keeps green for a guaranteed minimum interval. After that it keeps green for as long as the side road has no waiting traffic. Each yellow phase has a fixed length. The side road gets green for at most one long interval, and that green ends early as soon as the side-road vehicle sensor goes quiet.

Timing comes from a prescaler that turns the clock into a one-second tick, and from two interval timers counted in ticks. The long timer times the green phases and the short timer times the yellow phases. Whenever a phase is entered, its timer and the prescaler restart, so every phase is timed from its own first cycle. The sensor input is asynchronous and passes through a two-flop synchronizer before any decision uses it. Each road has one-hot red/yellow/green outputs. The current phase number is also brought out.

Top module: `junction_signal_ctrl`

In the requirements, D is CLKS_PER_TICK, L is LONG_TICKS and S is SHORT_TICKS. A phase's first cycle counts as elapsed cycle 0.

## Requirements
- R1: `phase_o` takes only the values 0 (main green), 1 (main yellow), 2 (side green) and 3 (side yellow). It only ever advances from 0 to 1, 1 to 2, 2 to 3, or 3 to 0.
- R2: Main green ends on the cycle after the first cycle in which the elapsed count is at least L*D and the synchronized sensor is high. It therefore lasts at least L*D+1 cycles, and it holds for any length while the sensor stays low.
- R3: Main yellow lasts exactly S*D+1 cycles.
- R4: Side green ends on the cycle after the first cycle in which the elapsed count is at least L*D or the synchronized sensor is low. It therefore never lasts more than L*D+1 cycles.
- R5: Side yellow lasts exactly S*D+1 cycles.
- R6: Lamp vectors are coded with bit 2 = red, bit 1 = yellow and bit 0 = green, and exactly one bit is set on each road. The side road shows red in phases 0 and 1, and the main road shows red in phases 2 and 3.
- R7: Synchronous reset `rst` gives phase 0, with the main road green and the side road red. All timing restarts, so the first main green after reset lasts at least L*D+1 cycles.
- R8: A sensor level applied before clock edge n reaches the phase decision in the cycle after edge n+1, so the resulting phase change appears at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| side_vehicle_i | input | 1 | Asynchronous side-road vehicle presence sensor |
| phase_o | output | 2 | Current phase number (0..3) |
| main_lamp_o | output | 3 | Main road lamps {red, yellow, green} |
| side_lamp_o | output | 3 | Side road lamps {red, yellow, green} |

## Verification
The phase number and both lamp vectors are combinational from the phase register. They change in the first cycle of a new phase, so the bench compares them every cycle, half a period after the edge. A sensor edge takes three edges to show at `phase_o`: two synchronizer stages and then the phase register. The bench model therefore delays its own copy of the sensor by two cycles, and the directed side-green check expects the phase to be unchanged for two sampled cycles and advanced on the third. Phase lengths are counted at the ports and compared with S*D+1 and L*D+1, which the bench computes from its parameters.

// File: rtl/junction_pkg.sv
package junction_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_WARN = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_WARN = 2'd3
  } phase_t;

  localparam logic [2:0] LAMP_RED = 3'b100;
  localparam logic [2:0] LAMP_YEL = 3'b010;
  localparam logic [2:0] LAMP_GRN = 3'b001;

  function automatic phase_t phase_after(phase_t p);
    case (p)
      PH_MAIN_GO:   return PH_MAIN_WARN;
      PH_MAIN_WARN: return PH_SIDE_GO;
      PH_SIDE_GO:   return PH_SIDE_WARN;
      default:      return PH_MAIN_GO;
    endcase
  endfunction

  function automatic logic is_green_phase(phase_t p);
    return (p == PH_MAIN_GO) || (p == PH_SIDE_GO);
  endfunction

  function automatic logic [2:0] main_lamps(phase_t p);
    case (p)
      PH_MAIN_GO:   return LAMP_GRN;
      PH_MAIN_WARN: return LAMP_YEL;
      default:      return LAMP_RED;
    endcase
  endfunction

  function automatic logic [2:0] side_lamps(phase_t p);
    case (p)
      PH_SIDE_GO:   return LAMP_GRN;
      PH_SIDE_WARN: return LAMP_YEL;
      default:      return LAMP_RED;
    endcase
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned CLKS_PER_TICK = 125_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

  logic [PW-1:0] div_q;
  logic          wrap;

  assign wrap   = (div_q == LAST);
  assign tick_o = wrap && !clear_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) div_q <= '0;
    else if (wrap)      div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  a_r3_div_bound: assert property (@(posedge clk) disable iff (rst)
    div_q <= LAST);

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned LIMIT_TICKS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT_TICKS + 1);
  localparam logic [CW-1:0] FINAL = CW'(LIMIT_TICKS - 1);

  logic [CW-1:0] count_q;
  logic          done_q;

  assign expired_o = done_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (tick_i && !done_q) begin
      count_q <= count_q + 1'b1;
      if (count_q == FINAL) done_q <= 1'b1;
    end
  end

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !expired_o);
  a_r2_expiry_sticks: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !restart_i) |=> expired_o);
  a_r3_count_waits_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i) |=> $stable(count_q));

endmodule

// File: rtl/sensor_sync.sv
module sensor_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import junction_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   vehicle_i,
  input  logic   long_done_i,
  input  logic   short_done_i,
  output phase_t phase_o,
  output logic   advance_o,
  output logic   restart_long_o,
  output logic   restart_short_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_MAIN_GO:   if (long_done_i && vehicle_i)   phase_d = phase_after(phase_q);
      PH_MAIN_WARN: if (short_done_i)               phase_d = phase_after(phase_q);
      PH_SIDE_GO:   if (long_done_i || !vehicle_i)  phase_d = phase_after(phase_q);
      default:      if (short_done_i)               phase_d = phase_after(phase_q);
    endcase
  end

  assign advance_o       = (phase_d != phase_q);
  assign restart_long_o  = advance_o && is_green_phase(phase_d);
  assign restart_short_o = advance_o && !is_green_phase(phase_d);
  assign phase_o         = phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_MAIN_GO;
    else     phase_q <= phase_d;
  end

  a_r1_order: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> (phase_q == phase_after($past(phase_q))));
  a_r2_main_hold: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAIN_GO && !(long_done_i && vehicle_i)) |=> phase_q == PH_MAIN_GO);
  a_r3_warn_hold: assert property (@(posedge clk) disable iff (rst)
    (!is_green_phase(phase_q) && !short_done_i) |=> $stable(phase_q));
  a_r4_side_exit: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SIDE_GO && (long_done_i || !vehicle_i)) |=> phase_q == PH_SIDE_WARN);

endmodule

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl
  import junction_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 125_000_000,
  parameter int unsigned LONG_TICKS    = 25,
  parameter int unsigned SHORT_TICKS   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       side_vehicle_i,
  output logic [1:0] phase_o,
  output logic [2:0] main_lamp_o,
  output logic [2:0] side_lamp_o
);
  localparam int unsigned N_TIMERS = 2;
  localparam int unsigned IDX_LONG = 0;
  localparam int unsigned IDX_SHORT = 1;

  logic   vehicle_s;
  logic   sec_tick;
  logic   advance;
  logic   restart_long, restart_short;
  phase_t phase;
  logic [N_TIMERS-1:0] timer_restart;
  logic [N_TIMERS-1:0] timer_done;

  sensor_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (side_vehicle_i),
    .sync_o  (vehicle_s)
  );

  tick_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (advance),
    .tick_o  (sec_tick)
  );

  assign timer_restart[IDX_LONG]  = restart_long;
  assign timer_restart[IDX_SHORT] = restart_short;

  for (genvar t = 0; t < N_TIMERS; t++) begin : g_timer
    localparam int unsigned LIM = (t == IDX_LONG) ? LONG_TICKS : SHORT_TICKS;
    interval_timer #(.LIMIT_TICKS(LIM)) u_timer (
      .clk       (clk),
      .rst       (rst),
      .restart_i (timer_restart[t]),
      .tick_i    (sec_tick),
      .expired_o (timer_done[t])
    );
  end

  phase_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .vehicle_i       (vehicle_s),
    .long_done_i     (timer_done[IDX_LONG]),
    .short_done_i    (timer_done[IDX_SHORT]),
    .phase_o         (phase),
    .advance_o       (advance),
    .restart_long_o  (restart_long),
    .restart_short_o (restart_short)
  );

  assign phase_o     = phase;
  assign main_lamp_o = main_lamps(phase);
  assign side_lamp_o = side_lamps(phase);

  a_r6_one_lamp_each: assert property (@(posedge clk) disable iff (rst)
    ($countones(main_lamp_o) == 1) && ($countones(side_lamp_o) == 1));
  a_r6_cross_red: assert property (@(posedge clk) disable iff (rst)
    main_lamp_o[2] || side_lamp_o[2]);
  a_r7_single_restart: assert property (@(posedge clk) disable iff (rst)
    $countones(timer_restart) <= 1);

endmodule

// File: tb/junction_signal_ctrl_tb_top.sv
module junction_signal_ctrl_tb_top;
  localparam int DIV  = 3;
  localparam int LNG  = 5;
  localparam int SHRT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vs  = 1'b0;
  logic [1:0] phase;
  logic [2:0] ml, sl;

  always #4 clk = ~clk;

  junction_signal_ctrl #(.CLKS_PER_TICK(DIV), .LONG_TICKS(LNG), .SHORT_TICKS(SHRT)) dut_i (
    .clk(clk), .rst(rst), .side_vehicle_i(vs),
    .phase_o(phase), .main_lamp_o(ml), .side_lamp_o(sl)
  );

  int  checks = 0, fails = 0;
  bit  done = 1'b0;
  int  m_ph = 0, m_c = 0;
  bit  m_f1 = 1'b0, m_f2 = 1'b0;
  int  d_len = 0;
  int  d_prev = 0;
  bit  fresh = 1'b1;

  function automatic int warn_len();  return SHRT * DIV + 1; endfunction
  function automatic int green_cap(); return LNG * DIV + 1;  endfunction

  function automatic logic [2:0] want_main(int p);
    if (p >= 2) return 3'b100;
    return (p == 0) ? 3'b001 : 3'b010;
  endfunction
  function automatic logic [2:0] want_side(int p);
    if (p < 2) return 3'b100;
    return (p == 2) ? 3'b001 : 3'b010;
  endfunction

  function automatic bit leaves(int p, int c, bit v);
    bit long_up  = (c >= LNG * DIV);
    bit short_up = (c >= SHRT * DIV);
    case (p)
      0: return long_up && v;
      2: return long_up || !v;
      default: return short_up;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic judge(int p, int len);
    case (p)
      0: chk(len >= green_cap(), fresh ? "R7 first main green" : "R2 main green", len, green_cap());
      1: chk(len == warn_len(), "R3 main yellow", len, warn_len());
      2: chk(len <= green_cap(), "R4 side green", len, green_cap());
      default: chk(len == warn_len(), "R5 side yellow", len, warn_len());
    endcase
    fresh = 1'b0;
  endtask

  task automatic step(bit vs_new, bit rst_new);
    @(negedge clk);
    if (rst) begin
      m_ph = 0; m_c = 0; m_f1 = 1'b0; m_f2 = 1'b0;
    end
    chk(int'(phase) == m_ph, "R1 phase", int'(phase), m_ph);
    chk(ml == want_main(m_ph), "R6 main lamps", int'(ml), int'(want_main(m_ph)));
    chk(sl == want_side(m_ph), "R6 side lamps", int'(sl), int'(want_side(m_ph)));
    if (rst) begin
      d_len = 1; d_prev = int'(phase); fresh = 1'b1;
    end else if (int'(phase) != d_prev) begin
      judge(d_prev, d_len);
      d_len = 1; d_prev = int'(phase);
    end else begin
      d_len++;
    end
    rst = rst_new;
    vs  = vs_new;
    if (leaves(m_ph, m_c, m_f2)) begin
      m_ph = (m_ph + 1) % 4; m_c = 0;
    end else begin
      m_c++;
    end
    m_f2 = m_f1;
    m_f1 = vs_new;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    // R7: reset state seen at the ports
    chk(phase == 2'd0 && ml == 3'b001 && sl == 3'b100, "R7 reset state", int'({phase, ml, sl}), 9'b00_001_100);
    // R2: no side traffic, main green holds well past its minimum
    repeat (3 * LNG * DIV) step(1'b0, 1'b0);
    chk(phase == 2'd0, "R2 hold without vehicle", int'(phase), 0);
    // R4: vehicle kept present, side green runs to its cap
    while (phase != 2'd3) step(1'b1, 1'b0);
    // R8: drop sensor at start of side green, change lands three edges later
    while (phase != 2'd2) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(phase == 2'd2, "R8 sync delay 1", int'(phase), 2);
    step(1'b0, 1'b0);
    chk(phase == 2'd2, "R8 sync delay 2", int'(phase), 2);
    step(1'b0, 1'b0);
    chk(phase == 2'd3, "R8 side ends", int'(phase), 3);
    // random sensor traffic, with a reset in the middle
    for (int i = 0; i < 2400; i++) begin
      bit nv = ($urandom % 8 == 0) ? !vs : vs;
      step(nv, (i >= 1200 && i < 1202));
      if (i == 1202)
        chk(phase == 2'd0 && sl == 3'b100, "R7 mid-run reset", int'(phase), 0);
    end
    repeat (3) step(1'b1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule